// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control side of a successive-approximation converter. A conversion is requested by a falling edge on an active-low start input while the chip select is low. The sequencer then runs a binary search, one bit per internal clock, from the most significant bit down. On each step it drives a trial code to an external DAC and reads back a single comparator bit that says whether the held input is at or above the DAC level.

While the search runs, the active-low busy output stays low. Further start edges are ignored until the conversion is over. After the last bit decision, one more cycle copies the result into a separate output latch. The search runs in offset binary, and the most significant bit is inverted on the way into the latch, so the latch holds a bipolar two's-complement code. The latch drives a parallel bus that is three-stated whenever chip select is high. Busy rises in the same cycle that the new result appears, so there is no pipeline delay.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only when convst_n is sampled high on one clock edge and low on the next while cs_n is low on that second edge. Holding convst_n low, or a falling edge while cs_n is high, starts nothing.
- R2: The search register is cleared at the start edge. In the cycle after the start edge, dac_code has only its most significant bit set (12'h800 at WIDTH=12).
- R3: While a conversion runs, further start edges are ignored. The conversion is neither restarted nor lengthened, and its result is that of the original search.
- R4: Bits are decided one per clock from the most significant bit down. A trial bit stays set when cmp_ge is 1 and is cleared when cmp_ge is 0, and the next lower bit is set as the following trial.
- R5: busy_n goes low on the start edge and stays low for exactly WIDTH+1 clock cycles: WIDTH decisions plus one latch cycle. It is high otherwise.
- R6: The output latch changes only on the edge where busy_n rises. During a conversion the bus still shows the previous result.
- R7: When cs_n is high, bus_en is 0 and data_bus is high-impedance. When cs_n is low, bus_en is 1 and data_bus carries the latched result.
- R8: The latched result is two's complement. It equals the signed input whose offset-binary form {~v[MSB], v[MSB-1:0]} the comparator tests against. An input of -1 gives all ones, 0 gives all zeros, 2047 gives 12'h7FF and -2048 gives 12'h800.
- R9: After synchronous reset, busy_n is 1, dac_code is 0 and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; gates starts and bus drive |
| convst_n | input | 1 | Convert start, active low; falling edge requests a conversion |
| cmp_ge | input | 1 | Comparator decision: 1 when input is at or above the DAC level |
| dac_code | output | WIDTH | Trial code driven to the DAC (offset binary) |
| busy_n | output | 1 | Low while a conversion is in progress |
| bus_en | output | 1 | High when the parallel bus is driven |
| data_bus | output | WIDTH | Three-state result bus, two's complement |

## Verification
The bench builds the block with the default WIDTH of 12. At that width a conversion lasts 13 cycles, so every trial code of a search can be compared step by step against the value computed from the input. Both extreme codes and the codes on either side of zero can also be driven directly. The comparator is modelled behaviourally from a stored signed input, so each expected result is simply that input value.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int DEFAULT_WIDTH = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LATCH  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic done;
    } seq_status_t;

endpackage

// File: rtl/sar_start_qual.sv
module sar_start_qual (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic convst_n,
    input  logic idle,
    output logic start
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b1;
        else     conv_q <= convst_n;
    end

    assign start = conv_q & ~convst_n & ~cs_n & idle;
endmodule

// File: rtl/sar_search_engine.sv
module sar_search_engine
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_ge,
    output logic [WIDTH-1:0] trial,
    output seq_status_t      status
);
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    seq_state_e       state;
    logic [IDX_W-1:0] bit_idx;
    logic [WIDTH-1:0] trial_nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign trial_nxt[i] = (bit_idx == IDX_W'(i)) ? cmp_ge : trial[i];
        end else begin : g_low
            assign trial_nxt[i] = (bit_idx == IDX_W'(i))     ? cmp_ge :
                                  (bit_idx == IDX_W'(i + 1)) ? 1'b1   : trial[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            trial   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        trial   <= MSB_ONLY;
                        bit_idx <= TOP_IDX;
                        state   <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    trial <= trial_nxt;
                    if (bit_idx == '0) state <= ST_LATCH;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                ST_LATCH: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign status.active = (state != ST_IDLE);
    assign status.done   = (state == ST_LATCH);
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] search_val,
    output logic [WIDTH-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= {~search_val[WIDTH-1], search_val[WIDTH-2:0]};
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             convst_n,
    input  logic             cmp_ge,
    output logic [WIDTH-1:0] dac_code,
    output logic             busy_n,
    output logic             bus_en,
    output logic [WIDTH-1:0] data_bus
);
    logic             start;
    seq_status_t      status;
    logic [WIDTH-1:0] held_q;

    sar_start_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .convst_n (convst_n),
        .idle     (~status.active),
        .start    (start)
    );

    sar_search_engine #(.WIDTH(WIDTH)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_ge (cmp_ge),
        .trial  (dac_code),
        .status (status)
    );

    sar_out_latch #(.WIDTH(WIDTH)) u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (status.done),
        .search_val (dac_code),
        .held       (held_q)
    );

    assign busy_n   = ~status.active;
    assign bus_en   = ~cs_n;
    assign data_bus = bus_en ? held_q : {WIDTH{1'bz}};
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             busy_n,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] held
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    logic [7:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || busy_n) low_cnt <= '0;
        else               low_cnt <= low_cnt + 1'b1;
    end

    AST_NO_START_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (busy_n && cs_n) |=> busy_n); // R1
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> (dac_code == MSB_ONLY)); // R2
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && low_cnt < 8'(WIDTH)) |=> !busy_n); // R3
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_cnt == 8'(WIDTH + 1))); // R5
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && low_cnt < 8'(WIDTH)) |=> $stable(held)); // R6
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .busy_n   (busy_n),
    .dac_code (dac_code),
    .held     (held_q)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic convst_n = 1'b1;
    logic [W-1:0] vin = '0;
    logic cmp_ge;
    logic [W-1:0] dac_code;
    logic busy_n, bus_en;
    wire  [W-1:0] data_bus;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // comparator model: held input (offset binary) at or above DAC level
    assign cmp_ge = ({~vin[W-1], vin[W-2:0]} >= dac_code);

    sar_conv_seq #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .convst_n(convst_n), .cmp_ge(cmp_ge),
        .dac_code(dac_code), .busy_n(busy_n), .bus_en(bus_en), .data_bus(data_bus)
    );

    // {input, expected two's-complement result}
    localparam logic [2*W-1:0] VEC [8] = '{
        {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h7FF, 12'h7FF}, {12'h800, 12'h800},
        {12'h123, 12'h123}, {12'hA5A, 12'hA5A}, {12'h001, 12'h001}, {12'hF00, 12'hF00}
    };

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one conversion; retrig_at >= 0 pulses convst_n again mid-conversion.
    task automatic run_conv(input logic [W-1:0] v, input int retrig_at,
                            output int busy_len, output bit seq_ok);
        logic [W-1:0] off;
        logic [W-1:0] exp_t;
        vin = v;
        off = {~v[W-1], v[W-2:0]};
        @(negedge clk);
        cs_n = 1'b0;
        convst_n = 1'b0;
        @(negedge clk);
        busy_len = 0;
        seq_ok = 1'b1;
        for (int k = 0; k < 40 && !busy_n; k++) begin
            if (k < W) begin
                exp_t = (off & ~((W'(1) << (W - k)) - W'(1))) | (W'(1) << (W - 1 - k));
                if (k == 0) exp_t = W'(1) << (W - 1);
                if (dac_code !== exp_t) seq_ok = 1'b0;
            end
            busy_len++;
            if (k == 0) convst_n = 1'b1;
            if (retrig_at >= 0 && k == retrig_at) convst_n = 1'b0;
            if (retrig_at >= 0 && k == retrig_at + 2) convst_n = 1'b1;
            @(negedge clk);
        end
        convst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int blen;
        bit sok;
        logic [W-1:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy_n == 1'b1, "R9 busy_n", W'(busy_n), W'(1));
        check(dac_code == '0, "R9 dac_code", dac_code, '0);
        cs_n = 1'b0;
        @(negedge clk);
        check(bus_en && data_bus == '0, "R9 latch", data_bus, '0);

        // table walk: R4 R5 R8
        foreach (VEC[i]) begin
            run_conv(VEC[i][2*W-1:W], -1, blen, sok);
            check(blen == W + 1, "R5 busy length", W'(blen), W'(W + 1));
            check(sok, "R4 trial sequence", dac_code, VEC[i][2*W-1:W]);
            check(data_bus == VEC[i][W-1:0], "R8 result", data_bus, VEC[i][W-1:0]);
        end

        // R1: falling edge with cs_n high starts nothing
        cs_n = 1'b1;
        @(negedge clk);
        convst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(busy_n, "R1 no start while deselected", W'(busy_n), W'(1));
        end
        // R1: level low then select -> still no start
        cs_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(busy_n, "R1 level is not an edge", W'(busy_n), W'(1));
        end
        convst_n = 1'b1;
        @(negedge clk);

        // R3 retrigger ignored, R6 previous value held mid-conversion
        prev = data_bus;
        vin = 12'h3C5;
        @(negedge clk);
        convst_n = 1'b0;
        @(negedge clk);
        convst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy_n && data_bus == prev, "R6 bus holds previous", data_bus, prev);
        convst_n = 1'b0;
        @(negedge clk);
        convst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_n, "R3 still busy after retrigger", W'(busy_n), W'(0));
        repeat (20) @(negedge clk);
        check(data_bus == 12'h3C5, "R3 result unaffected", data_bus, 12'h3C5);

        // R3 via task: retrigger pulse must not lengthen busy
        run_conv(12'h6B2, 4, blen, sok);
        check(blen == W + 1, "R3 busy not lengthened", W'(blen), W'(W + 1));
        check(data_bus == 12'h6B2, "R3 retrigger result", data_bus, 12'h6B2);

        // R2 first trial after start
        vin = 12'h0F0;
        @(negedge clk);
        convst_n = 1'b0;
        @(negedge clk);
        check(dac_code == 12'h800, "R2 cleared at start", dac_code, 12'h800);
        convst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R7 bus drive follows chip select
        cs_n = 1'b1;
        @(negedge clk);
        check(!bus_en, "R7 released when deselected", W'(bus_en), W'(0));
        cs_n = 1'b0;
        @(negedge clk);
        check(bus_en && data_bus == 12'h0F0, "R7 driven when selected", data_bus, 12'h0F0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule